// File: doc/BRIEF.md
# Fixed-Point Reciprocal and Inverse Square Root Estimator

This block computes an approximation of either 1/x or 1/sqrt(x) for a normalised operand x in the range [1.0, 2.0). The operand is a 16-bit unsigned Q1.15 value whose top bit is always set. A one-cycle start strobe loads the operand and a mode bit. The unit then works through a fixed sequence of steps and raises a one-cycle done strobe. The 16-bit Q1.15 result sits in the range [0.5, 1.0].

A small lookup table turns five operand bits into an 8-bit first estimate. Two Newton-Raphson refinements follow, both on one shared multiplier. The reciprocal refinement is y' = y*(2 - x*y). The inverse square root refinement is y' = y*(3 - x*y*y)/2. Intermediate values are kept with a parameterised number of fraction bits. They are reduced to Q1.15 only when the result is presented. The block suits a pipeline that normalises its operands beforehand, for example a perspective divide or a vector normalisation stage.

Top module: `recip_rsqrt_est`

## Requirements
- R1: After reset, busy_o and done_o are low.
- R2: A start_i pulse while busy_o is low captures operand_i and mode_i, and busy_o is high from the next cycle. mode_i = 0 selects reciprocal and mode_i = 1 selects reciprocal square root.
- R3: In reciprocal mode, result_o at done_o is within 2 LSB of 32768/x, where x = operand_i/32768.
- R4: In inverse square root mode, result_o at done_o is within 2 LSB of 32768/sqrt(x).
- R5: Counting the clock edge that samples start_i as edge 1, done_o is first high after edge 6 in reciprocal mode and after edge 8 in inverse square root mode.
- R6: done_o is high for exactly one cycle, with busy_o still high. busy_o is low in the next cycle.
- R7: A start_i pulse while busy_o is high changes neither the operation in progress nor its result, and starts no second operation.
- R8: result_o holds its value from done_o until the next accepted start_i, even if operand_i and mode_i change.
- R9: The operand 0x8000 (1.0) gives exactly 0x8000 in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, accepted only while idle |
| operand_i | input | 16 | Operand x, Q1.15, bit 15 set |
| mode_i | input | 1 | 0 = reciprocal, 1 = reciprocal square root |
| busy_o | output | 1 | High from the cycle after acceptance through the done cycle |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | 16 | Q1.15 estimate, valid at done_o and held afterwards |

## Verification
The bench sweeps every eighth legal operand in both modes, plus the smallest (0x8000) and largest (0xFFFF) operands. Each result is compared with a real-valued model, so the sweep reaches every table entry at several points within its interval. This separates a wrong seed or a wrong refinement formula from a small truncation error. Directed sequences apply a start during an operation, change the inputs after completion and measure latency per mode. These separate correct operand capture and result holding from leaks of later input activity.

// File: rtl/rcp_est_pkg.sv
package rcp_est_pkg;
   localparam int OPER_W = 16;
   localparam int IDX_W  = 5;
   localparam int SEED_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEED,
      ST_MUL_A,
      ST_MUL_B,
      ST_MUL_C,
      ST_DONE
   } est_state_e;
endpackage

// File: rtl/rcp_seed_rom.sv
module rcp_seed_rom
   import rcp_est_pkg::*;
(
   input  logic [IDX_W-1:0]  idx_i,
   input  logic              rsqrt_i,
   output logic [SEED_W-1:0] seed_o
);
   // Entry i holds 256/m and 256/sqrt(m), with m the midpoint 1+(i+0.5)/32.
   logic [2*SEED_W-1:0] pair;

   always_comb begin
      case (idx_i)
         5'd0:  pair = {8'd252, 8'd254};
         5'd1:  pair = {8'd245, 8'd250};
         5'd2:  pair = {8'd237, 8'd247};
         5'd3:  pair = {8'd231, 8'd243};
         5'd4:  pair = {8'd224, 8'd240};
         5'd5:  pair = {8'd218, 8'd236};
         5'd6:  pair = {8'd213, 8'd233};
         5'd7:  pair = {8'd207, 8'd230};
         5'd8:  pair = {8'd202, 8'd228};
         5'd9:  pair = {8'd197, 8'd225};
         5'd10: pair = {8'd193, 8'd222};
         5'd11: pair = {8'd188, 8'd220};
         5'd12: pair = {8'd184, 8'd217};
         5'd13: pair = {8'd180, 8'd215};
         5'd14: pair = {8'd176, 8'd212};
         5'd15: pair = {8'd172, 8'd210};
         5'd16: pair = {8'd169, 8'd208};
         5'd17: pair = {8'd165, 8'd206};
         5'd18: pair = {8'd162, 8'd204};
         5'd19: pair = {8'd159, 8'd202};
         5'd20: pair = {8'd156, 8'd200};
         5'd21: pair = {8'd153, 8'd198};
         5'd22: pair = {8'd150, 8'd196};
         5'd23: pair = {8'd148, 8'd194};
         5'd24: pair = {8'd145, 8'd193};
         5'd25: pair = {8'd142, 8'd191};
         5'd26: pair = {8'd140, 8'd189};
         5'd27: pair = {8'd138, 8'd188};
         5'd28: pair = {8'd135, 8'd186};
         5'd29: pair = {8'd133, 8'd185};
         5'd30: pair = {8'd131, 8'd183};
         default: pair = {8'd129, 8'd182};
      endcase
   end

   assign seed_o = rsqrt_i ? pair[SEED_W-1:0] : pair[2*SEED_W-1:SEED_W];
endmodule

// File: rtl/rcp_mul.sv
module rcp_mul #(
   parameter int W = 26
) (
   input  logic [W-1:0]   a_i,
   input  logic [W-1:0]   b_i,
   output logic [2*W-1:0] p_o
);
   if (W < 2) begin : g_bad_width
      $error("rcp_mul: W must be at least 2");
   end

   assign p_o = (2*W)'(a_i) * (2*W)'(b_i);
endmodule

// File: rtl/rcp_outfmt.sv
module rcp_outfmt #(
   parameter int FRAC_W = 24,
   parameter bit ROUND  = 1'b1
) (
   input  logic [FRAC_W+1:0] y_i,
   output logic [15:0]       res_o
);
   localparam int W     = FRAC_W + 2;
   localparam int SHIFT = FRAC_W - 15;

   if (ROUND) begin : g_round
      logic [W-1:0] sum;
      logic         unused_round;
      assign sum          = y_i + (W'(1) << (SHIFT - 1));
      assign res_o        = sum[SHIFT +: 16];
      assign unused_round = ^{sum[SHIFT-1:0], sum[W-1]};
   end else begin : g_trunc
      logic unused_trunc;
      assign res_o        = y_i[SHIFT +: 16];
      assign unused_trunc = ^{y_i[SHIFT-1:0], y_i[W-1]};
   end
endmodule

// File: rtl/recip_rsqrt_est.sv
module recip_rsqrt_est
   import rcp_est_pkg::*;
#(
   parameter int FRAC_W = 24,
   parameter bit ROUND  = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   input  logic [15:0] operand_i,
   input  logic        mode_i,
   output logic        busy_o,
   output logic        done_o,
   output logic [15:0] result_o
);
   localparam int W = FRAC_W + 2;

   if (FRAC_W < 16 || FRAC_W > 30) begin : g_bad_frac
      $error("recip_rsqrt_est: FRAC_W must lie in 16..30");
   end

   est_state_e        st_q;
   logic [OPER_W-1:0] x_q;
   logic              mode_q;
   logic              iter_q;
   logic [W-1:0]      y_q, t_q;
   logic [W-1:0]      x_ext, seed_ext, k_const, mul_a, mul_b, prod_lo, prod_hf;
   logic [2*W-1:0]    prod;
   logic [SEED_W-1:0] seed;
   logic              unused_prod;

   rcp_seed_rom u_seed (
      .idx_i   (x_q[OPER_W-2 -: IDX_W]),
      .rsqrt_i (mode_q),
      .seed_o  (seed)
   );

   assign x_ext    = W'(x_q) << (FRAC_W - 15);
   assign seed_ext = W'(seed) << (FRAC_W - SEED_W);
   assign k_const  = mode_q ? (W'(3) << FRAC_W) : (W'(2) << FRAC_W);

   // Operand steering for the shared multiplier
   always_comb begin
      mul_a = y_q;
      mul_b = y_q;
      case (st_q)
         ST_MUL_A: begin
            mul_a = mode_q ? y_q : x_ext;
            mul_b = y_q;
         end
         ST_MUL_B: begin
            mul_a = x_ext;
            mul_b = t_q;
         end
         ST_MUL_C: begin
            mul_a = y_q;
            mul_b = k_const - t_q;
         end
         default: ;
      endcase
   end

   rcp_mul #(.W(W)) u_mul (
      .a_i (mul_a),
      .b_i (mul_b),
      .p_o (prod)
   );

   assign prod_lo     = prod[FRAC_W +: W];
   assign prod_hf     = prod[FRAC_W+1 +: W];
   assign unused_prod = ^{prod[FRAC_W-1:0], prod[2*W-1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         x_q    <= '0;
         mode_q <= 1'b0;
         iter_q <= 1'b0;
         y_q    <= '0;
         t_q    <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  x_q    <= operand_i;
                  mode_q <= mode_i;
                  iter_q <= 1'b0;
                  st_q   <= ST_SEED;
               end
            end
            ST_SEED: begin
               y_q  <= seed_ext;
               st_q <= ST_MUL_A;
            end
            ST_MUL_A: begin
               t_q  <= prod_lo;
               st_q <= mode_q ? ST_MUL_B : ST_MUL_C;
            end
            ST_MUL_B: begin
               t_q  <= prod_lo;
               st_q <= ST_MUL_C;
            end
            ST_MUL_C: begin
               y_q <= mode_q ? prod_hf : prod_lo;
               if (iter_q) begin
                  st_q <= ST_DONE;
               end else begin
                  iter_q <= 1'b1;
                  st_q   <= ST_MUL_A;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   rcp_outfmt #(.FRAC_W(FRAC_W), .ROUND(ROUND)) u_fmt (
      .y_i   (y_q),
      .res_o (result_o)
   );

   assign busy_o = (st_q != ST_IDLE);
   assign done_o = (st_q == ST_DONE);

   // R2: an accepted start makes the unit busy next cycle
   a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> busy_o);

   // R6: done lasts one cycle and the unit is idle afterwards
   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !busy_o));

   // R7: captured operand and mode stay fixed while working
   a_r7_operands_held: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o) |=> ($stable(x_q) && $stable(mode_q)));

   // R3 and R4: any finished estimate lies in [0.5, 1.0]
   a_r3_result_range: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (result_o >= 16'h4000 && result_o <= 16'h8000));

   // R8: the result holds while idle without a start
   a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(result_o));
endmodule

// File: tb/recip_rsqrt_est_tb.sv
`timescale 1ns/1ps
module recip_rsqrt_est_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] xin = 16'h8000;
   logic        mode = 1'b0;
   logic        busy, done;
   logic [15:0] res;
   int          checks = 0;
   int          fails = 0;
   logic [15:0] r, r2;
   int          lat;

   always #2 clk = ~clk;

   recip_rsqrt_est dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start),
      .operand_i (xin),
      .mode_i    (mode),
      .busy_o    (busy),
      .done_o    (done),
      .result_o  (res)
   );

   function automatic real ref_val(input logic [15:0] x, input bit m);
      real xr;
      xr = real'(x) / 32768.0;
      return m ? 32768.0 / $sqrt(xr) : 32768.0 / xr;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input real act, input real exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0f expected=%0f", req, what, act, exp);
      end
   endtask

   task automatic run(input logic [15:0] x, input bit m,
                      output logic [15:0] rv, output int lv);
      @(negedge clk);
      start = 1'b1;
      xin   = x;
      mode  = m;
      @(negedge clk);
      start = 1'b0;
      lv = 1;
      while (!done && lv < 40) begin
         @(negedge clk);
         lv++;
      end
      rv = res;
   endtask

   task automatic check_op(input logic [15:0] x, input bit m);
      real e, d;
      run(x, m, r, lat);
      e = ref_val(x, m);
      d = real'(r) - e;
      if (d < 0.0) d = -d;
      if (m) chk(d <= 2.0, "R4", "rsqrt error", real'(r), e);
      else   chk(d <= 2.0, "R3", "recip error", real'(r), e);
      chk(lat == (m ? 8 : 6), "R5", "latency", real'(lat), real'(m ? 8 : 6));
   endtask

   initial begin
      #(4 * 190000);
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: idle after reset
      chk(busy == 1'b0, "R1", "busy after reset", real'(busy), 0.0);
      chk(done == 1'b0, "R1", "done after reset", real'(done), 0.0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: busy in the cycle after the start is sampled
      start = 1'b1; xin = 16'hA000; mode = 1'b0;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R2", "busy after start", real'(busy), 1.0);
      lat = 1;
      while (!done && lat < 40) begin
         @(negedge clk);
         lat++;
      end
      // R6: done with busy high, then both low
      chk(busy == 1'b1, "R6", "busy during done", real'(busy), 1.0);
      @(negedge clk);
      chk(done == 1'b0, "R6", "done width", real'(done), 0.0);
      chk(busy == 1'b0, "R6", "busy after done", real'(busy), 0.0);

      // R9: exact unit operand
      run(16'h8000, 1'b0, r, lat);
      chk(r == 16'h8000, "R9", "recip of one", real'(r), 32768.0);
      run(16'h8000, 1'b1, r, lat);
      chk(r == 16'h8000, "R9", "rsqrt of one", real'(r), 32768.0);

      // R7: start during an operation is ignored
      @(negedge clk);
      start = 1'b1; xin = 16'h8000; mode = 1'b0;
      @(negedge clk);
      start = 1'b1; xin = 16'hC000; mode = 1'b1;
      @(negedge clk);
      start = 1'b0; xin = 16'hF000; mode = 1'b1;
      lat = 2;
      while (!done && lat < 40) begin
         @(negedge clk);
         lat++;
      end
      chk(res == 16'h8000, "R7", "result with mid-op start", real'(res), 32768.0);
      chk(lat == 6, "R7", "latency with mid-op start", real'(lat), 6.0);
      begin
         int extra = 0;
         for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (done || busy) extra++;
         end
         chk(extra == 0, "R7", "no second operation", real'(extra), 0.0);
      end

      // R8: result held while inputs move
      run(16'hB504, 1'b1, r, lat);
      @(negedge clk);
      xin = 16'h9000; mode = 1'b0;
      repeat (5) @(negedge clk);
      r2 = res;
      chk(r2 == r, "R8", "result hold", real'(r2), real'(r));

      // R3, R4, R5: sweep and end points
      for (int i = 32768; i < 65536; i += 8) begin
         check_op(16'(i), 1'b0);
         check_op(16'(i), 1'b1);
      end
      check_op(16'hFFFF, 1'b0);
      check_op(16'hFFFF, 1'b1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule